// File: doc/BRIEF.md
# Slip-Stacking Frequency Offset Sequencer

This block generates, one value per revolution, the frequency offset that pulls two RF cavity groups apart so that two particle batches held at nearly the same frequency slide past each other in phase. Before a run, software sets a target offset, an offset ceiling, a per-turn slope limit and a phase-slip threshold. A start pulse launches the run. On every revolution strobe the offset moves toward the target, by no more than the slope limit, and stays inside the ceiling. The block drives the offset to group A and its negation to group B, in frequency-tuning-word units.

On each turn the offset just applied is added to a running slip total for each batch. Both totals are visible at the ports the whole time, so downstream logic can see the approach to recapture. When the size of the slip reaches the threshold, the block raises a done flag. It then slews the offset back to zero under the same slope limit and returns to idle. The done flag stays high until the next start.

Top module: `slip_offset_seq`

## Requirements
- R1: While rst_n is low at a rising clock edge, both offsets and both slip totals become zero, and busy and slip_done become low.
- R2: The offsets and the slip totals change only on a clock edge where rev_tick is high while busy is high.
- R3: On each advancing turn the offset changes by at most cfg_max_slope in either direction, provided the previous offset was inside the current ceiling.
- R4: After each advancing turn the group A offset lies within ±cfg_max_ofs. A target beyond the ceiling is replaced by the ceiling value with the target's sign.
- R5: While ramping, the offset steps by exactly cfg_max_slope toward the clamped target. Once the remaining distance is no larger than the slope, it lands exactly on the clamped target and holds there.
- R6: ofs_grp_b always equals the two's-complement negation of ofs_grp_a, and slip_b always equals the negation of slip_a.
- R7: On each advancing turn, slip_a increases by the new group A offset (sign-extended, 48-bit two's complement). slip_b decreases by the same amount.
- R8: slip_done rises on the advancing turn after which |slip_a| is at least cfg_slip_thr. It stays high until the next accepted start, which clears it.
- R9: After slip_done rises, each turn moves the offset toward zero by at most cfg_max_slope. The slip totals keep accumulating. busy falls on the turn that brings the offset to zero, and never while the offset is nonzero.
- R10: A start pulse while busy is high is ignored: the run, slip_done and the slip totals continue unaffected.
- R11: A start pulse while idle clears both slip totals and slip_done and sets busy at the next edge. The first offset step comes with the next rev_tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rev_tick | input | 1 | One-cycle revolution strobe; one ramp step per strobe |
| start | input | 1 | One-cycle request to begin a slip run |
| cfg_target | input | OFS_W | Signed target offset for group A |
| cfg_max_ofs | input | OFS_W-1 | Offset ceiling magnitude |
| cfg_max_slope | input | OFS_W-1 | Largest offset change per turn |
| cfg_slip_thr | input | ACC_W-1 | Slip magnitude that ends the ramp |
| ofs_grp_a | output | OFS_W | Signed offset for cavity group A |
| ofs_grp_b | output | OFS_W | Signed offset for cavity group B (negated) |
| slip_a | output | ACC_W | Accumulated slip of batch A |
| slip_b | output | ACC_W | Accumulated slip of batch B |
| busy | output | 1 | Run in progress (ramp or return) |
| slip_done | output | 1 | Slip threshold reached in the current run |

## Verification
The embedded properties check on every cycle that offsets move only on strobes, respect the slope and ceiling bounds, and keep the two groups mirrored. They also check that each slip total grows by the offset just applied, that idle is entered only at zero offset, and that the done flag changes only on a strobe or a start. What only the bench scenarios can show is the shape of each run against the reference model. This covers exact landing on a clamped target, the turn on which the threshold is crossed (including a zero threshold), the full return to idle, and a start pulse that arrives mid-run and is ignored.

// File: rtl/slip_seq_pkg.sv
// Package: shared state type for the slip offset sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package slip_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SLEW   = 2'd1,
        SEQ_RETURN = 2'd2
    } seq_state_t;

endpackage

// File: rtl/ofs_slew_step.sv
// Module: ofs_slew_step
// Computes the next offset from the current one: it clamps the goal to
// +/-lim, moves toward it by at most slope, and clamps the result again.
// Purely combinational.
// Assumes: cur and goal are two's complement; lim and slope are magnitudes.
module ofs_slew_step #(
    parameter int W = 32
) (
    input  logic signed [W-1:0] cur,
    input  logic signed [W-1:0] goal,
    input  logic        [W-2:0] lim,
    input  logic        [W-2:0] slope,
    output logic signed [W-1:0] nxt
);
    localparam int XW = W + 2;

    logic signed [XW-1:0] cur_x;
    logic signed [XW-1:0] goal_x;
    logic signed [XW-1:0] lim_x;
    logic signed [XW-1:0] slope_x;
    logic signed [XW-1:0] goal_c;
    logic signed [XW-1:0] diff;
    logic signed [XW-1:0] raw;
    logic signed [XW-1:0] raw_c;

    // Bound a value to the symmetric window +/-l.
    function automatic logic signed [XW-1:0] clamp_x(
        input logic signed [XW-1:0] v,
        input logic signed [XW-1:0] l
    );
        if (v > l)       return l;
        else if (v < -l) return -l;
        else             return v;
    endfunction

    assign cur_x   = {{2{cur[W-1]}}, cur};
    assign goal_x  = {{2{goal[W-1]}}, goal};
    assign lim_x   = {3'b000, lim};
    assign slope_x = {3'b000, slope};

    // Slope-limited move toward the clamped goal, then clamp the result.
    always_comb begin
        goal_c = clamp_x(goal_x, lim_x);
        diff   = goal_c - cur_x;
        if (diff > slope_x)       raw = cur_x + slope_x;
        else if (diff < -slope_x) raw = cur_x - slope_x;
        else                      raw = goal_c;
        raw_c  = clamp_x(raw, lim_x);
    end

    assign nxt = raw_c[W-1:0];

endmodule

// File: rtl/slip_accum.sv
// Module: slip_accum
// Per-batch slip accumulator. It adds (or, with NEG set, subtracts) the
// sign-extended offset on each enabled cycle and clears on request.
// It also exposes the sum it would load, for threshold decisions.
// Assumes: AW > OW; wraps in AW-bit two's complement.
module slip_accum #(
    parameter int OW  = 32,
    parameter int AW  = 48,
    parameter bit NEG = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic signed [OW-1:0] addend,
    output logic signed [AW-1:0] acc_q,
    output logic signed [AW-1:0] acc_nxt
);
    localparam int EXT = AW - OW;

    logic signed [AW-1:0] addend_x;
    logic signed [AW-1:0] term;

    assign addend_x = {{EXT{addend[OW-1]}}, addend};

    // The parameter picks the sign of the contribution.
    generate
        if (NEG) begin : g_sub
            assign term = -addend_x;
        end else begin : g_add
            assign term = addend_x;
        end
    endgenerate

    assign acc_nxt = acc_q + term;

    // Running sum register: reset, clear on start, add on each turn.
    always_ff @(posedge clk) begin
        if (!rst_n)   acc_q <= '0;
        else if (clr) acc_q <= '0;
        else if (en)  acc_q <= acc_nxt;
    end

    // R7: the sum moves by exactly the signed contribution on enabled turns
    a_r7_accum_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (acc_q == $past(acc_q) + $past(term)));

endmodule

// File: rtl/slip_seq_ctrl.sv
// Module: slip_seq_ctrl
// Run-control FSM: idle -> slew toward target -> return to zero -> idle.
// It latches the done flag when either batch's next slip magnitude reaches
// the threshold on a turn.
// Assumes: start and rev_tick are single-cycle pulses in the clk domain.
module slip_seq_ctrl
    import slip_seq_pkg::*;
#(
    parameter int AW = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 rev_tick,
    input  logic signed [AW-1:0] acc_nxt_a,
    input  logic signed [AW-1:0] acc_nxt_b,
    input  logic        [AW-2:0] thr,
    input  logic                 step_zero,
    output seq_state_t           state,
    output logic                 busy,
    output logic                 done,
    output logic                 clr,
    output logic                 adv
);
    localparam int XW = AW + 1;

    logic [XW-1:0] mag_a;
    logic [XW-1:0] mag_b;
    logic [XW-1:0] thr_x;
    logic          reached;

    // Magnitude of a signed sum, widened so the most negative value fits.
    function automatic logic [XW-1:0] mag_of(input logic signed [AW-1:0] v);
        logic signed [XW-1:0] vx;
        vx = {v[AW-1], v};
        return v[AW-1] ? XW'(-vx) : XW'(vx);
    endfunction

    assign mag_a   = mag_of(acc_nxt_a);
    assign mag_b   = mag_of(acc_nxt_b);
    assign thr_x   = {2'b00, thr};
    assign reached = (mag_a >= thr_x) || (mag_b >= thr_x);

    assign busy = (state != SEQ_IDLE);
    assign clr  = (state == SEQ_IDLE) && start;
    assign adv  = busy && rev_tick;

    // Sequencing of run phases and the sticky done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            done  <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state <= SEQ_SLEW;
                        done  <= 1'b0;
                    end
                end
                SEQ_SLEW: begin
                    if (rev_tick && reached) begin
                        state <= SEQ_RETURN;
                        done  <= 1'b1;
                    end
                end
                SEQ_RETURN: begin
                    if (rev_tick && step_zero) state <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // R8: done only rises as the result of a revolution strobe
    a_r8_done_on_turn: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rev_tick));

    // R8: done only clears through an accepted start
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(start));

    // R11: start from idle launches a run with done cleared
    a_r11_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done));

endmodule

// File: rtl/slip_offset_seq.sv
// Module: slip_offset_seq (top)
// Per-turn slope-limited frequency offset ramp for two mirrored cavity
// groups. It accumulates the phase slip of each batch and ends the ramp on
// a slip threshold, then returns the offset to zero.
// Assumes: configuration inputs are held by software; ACC_W > OFS_W.
module slip_offset_seq
    import slip_seq_pkg::*;
#(
    parameter int OFS_W = 32,
    parameter int ACC_W = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rev_tick,
    input  logic                    start,
    input  logic signed [OFS_W-1:0] cfg_target,
    input  logic        [OFS_W-2:0] cfg_max_ofs,
    input  logic        [OFS_W-2:0] cfg_max_slope,
    input  logic        [ACC_W-2:0] cfg_slip_thr,
    output logic signed [OFS_W-1:0] ofs_grp_a,
    output logic signed [OFS_W-1:0] ofs_grp_b,
    output logic signed [ACC_W-1:0] slip_a,
    output logic signed [ACC_W-1:0] slip_b,
    output logic                    busy,
    output logic                    slip_done
);
    localparam int NGRP = 2;
    localparam int DW   = OFS_W + 2;
    localparam int SEXT = ACC_W - OFS_W;

    seq_state_t              state;
    logic                    clr;
    logic                    adv;
    logic                    step_zero;
    logic signed [OFS_W-1:0] ofs_q;
    logic signed [OFS_W-1:0] goal;
    logic signed [OFS_W-1:0] step_nxt;
    logic signed [ACC_W-1:0] acc_q   [NGRP];
    logic signed [ACC_W-1:0] acc_nxt [NGRP];

    // Goal is the programmed target while slewing and zero on the way back.
    assign goal      = (state == SEQ_RETURN) ? '0 : cfg_target;
    assign step_zero = (step_nxt == '0);

    ofs_slew_step #(.W(OFS_W)) step_i (
        .cur   (ofs_q),
        .goal  (goal),
        .lim   (cfg_max_ofs),
        .slope (cfg_max_slope),
        .nxt   (step_nxt)
    );

    // Offset register: loads the next step once per active turn.
    always_ff @(posedge clk) begin
        if (!rst_n)   ofs_q <= '0;
        else if (adv) ofs_q <= step_nxt;
    end

    // One slip accumulator per batch; group B carries the negated offset.
    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            slip_accum #(
                .OW  (OFS_W),
                .AW  (ACC_W),
                .NEG (g == 1)
            ) acc_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (clr),
                .en      (adv),
                .addend  (step_nxt),
                .acc_q   (acc_q[g]),
                .acc_nxt (acc_nxt[g])
            );
        end
    endgenerate

    slip_seq_ctrl #(.AW(ACC_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rev_tick  (rev_tick),
        .acc_nxt_a (acc_nxt[0]),
        .acc_nxt_b (acc_nxt[1]),
        .thr       (cfg_slip_thr),
        .step_zero (step_zero),
        .state     (state),
        .busy      (busy),
        .done      (slip_done),
        .clr       (clr),
        .adv       (adv)
    );

    assign ofs_grp_a = ofs_q;
    assign ofs_grp_b = -ofs_q;
    assign slip_a    = acc_q[0];
    assign slip_b    = acc_q[1];

    // Widened copies used only by the checks below.
    logic signed [DW-1:0] ofs_dx;
    logic signed [DW-1:0] slope_dx;
    logic signed [DW-1:0] lim_dx;
    assign ofs_dx   = {{2{ofs_q[OFS_W-1]}}, ofs_q};
    assign slope_dx = {3'b000, cfg_max_slope};
    assign lim_dx   = {3'b000, cfg_max_ofs};

    // R2: offset is frozen between active turns
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(rev_tick && busy) |=> $stable(ofs_q));

    // R3: per-turn change bounded by the slope limit
    a_r3_slope: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_tick && busy && ofs_dx <= lim_dx && ofs_dx >= -lim_dx) |=>
        ((ofs_dx - $past(ofs_dx)) <= $past(slope_dx) &&
         (ofs_dx - $past(ofs_dx)) >= -$past(slope_dx)));

    // R4: offset inside the ceiling after every active turn
    a_r4_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_tick && busy) |=> (ofs_dx <= $past(lim_dx) && ofs_dx >= -$past(lim_dx)));

    // R6: the two batch slip totals stay mirrored
    a_r6_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q[1] == -acc_q[0]);

    // R7: batch A slip grows by the offset now applied
    a_r7_slip_tracks_ofs: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_tick && busy) |=> (acc_q[0] == $past(acc_q[0]) + {{SEXT{ofs_q[OFS_W-1]}}, ofs_q}));

    // R9: idle is entered only with zero offset
    a_r9_idle_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (ofs_q == '0));

    // R10: start while busy and between turns leaves the run untouched
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !rev_tick) |=> (busy && $stable(slip_done) && $stable(acc_q[0])));

endmodule

// File: tb/slip_offset_seq_tb_top.sv
// Bench: behavioural reference model updated on every rising edge and
// compared with the outputs at every falling edge, plus directed checks.
module slip_offset_seq_tb_top;
    localparam int OW = 32;
    localparam int AW = 48;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 rev_tick = 1'b0;
    logic                 start = 1'b0;
    logic signed [OW-1:0] cfg_target = '0;
    logic        [OW-2:0] cfg_max_ofs = '0;
    logic        [OW-2:0] cfg_max_slope = '0;
    logic        [AW-2:0] cfg_slip_thr = '0;
    logic signed [OW-1:0] ofs_grp_a;
    logic signed [OW-1:0] ofs_grp_b;
    logic signed [AW-1:0] slip_a;
    logic signed [AW-1:0] slip_b;
    logic                 busy;
    logic                 slip_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    slip_offset_seq #(.OFS_W(OW), .ACC_W(AW)) dut_i (
        .clk, .rst_n, .rev_tick, .start, .cfg_target, .cfg_max_ofs,
        .cfg_max_slope, .cfg_slip_thr, .ofs_grp_a, .ofs_grp_b,
        .slip_a, .slip_b, .busy, .slip_done
    );

    // Reference model state: 0 idle, 1 ramping, 2 returning.
    int    m_phase = 0;
    longint m_ofs  = 0;
    longint m_slip = 0;
    bit    m_done  = 1'b0;

    function automatic longint bound(longint v, longint l);
        if (v > l)  return l;
        if (v < -l) return -l;
        return v;
    endfunction

    function automatic longint next_step(longint cur, longint goal, longint l, longint s);
        longint g;
        longint r;
        g = bound(goal, l);
        if (g - cur > s)       r = cur + s;
        else if (g - cur < -s) r = cur - s;
        else                   r = g;
        return bound(r, l);
    endfunction

    function automatic longint absl(longint v);
        return (v < 0) ? -v : v;
    endfunction

    // Model update on the same edge the design samples.
    always @(posedge clk) begin
        longint n;
        if (!rst_n) begin
            m_phase = 0; m_ofs = 0; m_slip = 0; m_done = 1'b0;
        end else begin
            case (m_phase)
                0: if (start) begin m_phase = 1; m_slip = 0; m_done = 1'b0; end
                1: if (rev_tick) begin
                    n = next_step(m_ofs, longint'(cfg_target), longint'(cfg_max_ofs), longint'(cfg_max_slope));
                    m_ofs = n; m_slip = m_slip + n;
                    if (absl(m_slip) >= longint'(cfg_slip_thr)) begin m_phase = 2; m_done = 1'b1; end
                end
                default: if (rev_tick) begin
                    n = next_step(m_ofs, 0, longint'(cfg_max_ofs), longint'(cfg_max_slope));
                    m_ofs = n; m_slip = m_slip + n;
                    if (n == 0) m_phase = 0;
                end
            endcase
        end
    end

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (!finished) begin
            check(longint'(ofs_grp_a) == m_ofs, "R3/R4/R5 ofs_grp_a", longint'(ofs_grp_a), m_ofs);
            check(longint'(ofs_grp_b) == -m_ofs, "R6 ofs_grp_b", longint'(ofs_grp_b), -m_ofs);
            check(longint'(slip_a) == m_slip, "R7 slip_a", longint'(slip_a), m_slip);
            check(longint'(slip_b) == -m_slip, "R6 slip_b", longint'(slip_b), -m_slip);
            check(slip_done == m_done, "R8 slip_done", longint'(slip_done), longint'(m_done));
            check(busy == (m_phase != 0), "R9/R11 busy", longint'(busy), longint'(m_phase != 0));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic turn();
        rev_tick = 1'b1; cyc(1); rev_tick = 1'b0; cyc(2);
    endtask

    task automatic go();
        start = 1'b1; cyc(1); start = 1'b0;
    endtask

    task automatic run_to_idle();
        for (int i = 0; i < 500 && busy; i++) turn();
    endtask

    task automatic report();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        longint hold;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        check(ofs_grp_a == 0 && slip_a == 0 && !busy && !slip_done, "R1 reset", longint'(busy), 0);

        // Scenario: positive target inside the ceiling.
        cfg_target = 1000; cfg_max_ofs = 5000; cfg_max_slope = 300; cfg_slip_thr = 20000;
        go();
        check(busy && slip_a == 0, "R11 launch", longint'(slip_a), 0);
        // R11: no step before the first strobe
        cyc(3);
        check(ofs_grp_a == 0, "R11 no step before tick", longint'(ofs_grp_a), 0);
        turn();
        check(ofs_grp_a == 300, "R5 first step", longint'(ofs_grp_a), 300);
        hold = longint'(ofs_grp_a);
        cyc(2);
        check(longint'(ofs_grp_a) == hold, "R2 hold between ticks", longint'(ofs_grp_a), hold);
        repeat (5) turn();
        check(ofs_grp_a == 1000, "R5 land on target", longint'(ofs_grp_a), 1000);
        run_to_idle();
        check(!busy && ofs_grp_a == 0, "R9 back to idle at zero", longint'(ofs_grp_a), 0);
        check(slip_done == 1'b1, "R8 done sticky after idle", longint'(slip_done), 1);

        // Scenario: negative target beyond the ceiling, with a mid-run start.
        cfg_target = -9000; cfg_max_ofs = 2000; cfg_max_slope = 700; cfg_slip_thr = 15000;
        go();
        check(slip_a == 0 && !slip_done, "R11 clears slip and done", longint'(slip_a), 0);
        repeat (5) turn();
        check(ofs_grp_a == -2000, "R4 clamped target", longint'(ofs_grp_a), -2000);
        hold = longint'(slip_a);
        go();
        cyc(1);
        check(busy && longint'(slip_a) == hold, "R10 start ignored", longint'(slip_a), hold);
        run_to_idle();
        check(!busy && slip_done, "R8/R9 run completes", longint'(busy), 0);

        // Scenario: zero threshold ends the ramp on the first turn.
        cfg_target = 50; cfg_max_ofs = 5000; cfg_max_slope = 100; cfg_slip_thr = 0;
        go();
        turn();
        check(slip_done && ofs_grp_a == 50, "R8 zero threshold", longint'(slip_done), 1);
        turn();
        check(!busy && ofs_grp_a == 0, "R9 single-step return", longint'(ofs_grp_a), 0);

        // Scenario: reset in the middle of a run.
        cfg_slip_thr = 100000;
        go();
        repeat (3) turn();
        rst_n = 1'b0; cyc(1); rst_n = 1'b1; cyc(1);
        check(!busy && ofs_grp_a == 0 && slip_a == 0 && !slip_done, "R1 reset mid-run", longint'(busy), 0);
        cyc(2);
        report();
    end

endmodule